// File: doc/BRIEF.md
# Queue Pointer Controller

This block holds a read pointer and a write pointer for each of a parameterised set of hardware queues and exposes them on a simple 32-bit register bus. Host software never loads a pointer directly. It moves a pointer forward by writing an increment to that queue's add register, and it reads the current positions back from two status registers. Every queue occupies its own 2 KB window inside a fixed queue region. Pointer arithmetic wraps modulo the queue depth, which is a power of two fixed at elaboration time.

Two flags sit beside the pointers. The first is a sticky overflow flag. It is raised when a producer advances the write pointer past the point where the ring would hold more entries than it has slots. The second is an empty flag. It is computed from the pointers with one extra wrap bit, so a completely full ring is not mistaken for an empty one.

A single add may advance a pointer by at most 63 entries. Software issues larger advances as several writes. Read data is registered, so it appears on the clock after the read strobe.

Top module: `mmq_ptr_ctrl`

## Requirements
- R1: After reset every pointer is zero, every overflow flag is clear, and every queue reports empty (write-status register reads 0x8000_0000).
- R2: A bus write at window offset 0x4 adds the clipped write data to that queue's write pointer, and the write-status register at offset 0xC returns the write pointer in bits 17:0.
- R3: A bus write at window offset 0x0 adds the clipped write data to that queue's read pointer, and the read-status register at offset 0x8 returns the read pointer in bits 17:0.
- R4: Any add value above 63 is clipped to 63, and an add of zero leaves the pointer unchanged.
- R5: Pointers wrap modulo the queue depth of 2^QSZ_LOG2 entries, and the status registers show only the wrapped position.
- R6: Bit 31 of the read-status register is an overflow flag. It sets when a write-pointer add would make the fill level (write minus read) exceed the queue depth. A fill exactly equal to the depth does not set it. Once set it stays set until reset, and the pointer still advances.
- R7: Bit 31 of the write-status register is 1 exactly when the read and write pointers are equal, including the wrap bit. A full ring reads as not empty.
- R8: The queue region covers bus addresses 0x80000 to 0xFFFFF. Bits 18:11 select the queue window, bits 10:0 select the register, and a write to one queue never moves another queue's pointers.
- R9: Reads return zero, and writes have no effect, for addresses outside the region, for queue indices at or above NUM_QUEUES, for window offsets other than 0x0, 0x4, 0x8 and 0xC, and for reads of the two add offsets.
- R10: Read data is registered on the clock edge where the read strobe is high, and it holds its value while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data (the add amount) |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |

## Verification
The assertions assume that the bus presents at most one access per cycle on a single shared address. They also assume the strobes are known (not X) outside reset. Reads are assumed not to move any state, so between writes the pointers are expected to be frozen. The bench changes inputs only on the falling clock edge and drives one access at a time. It does not advance a read pointer past the fill level, so the overflow and empty expectations follow from simple arithmetic on the adds issued.

// File: rtl/mmq_pkg.sv
package mmq_pkg;

    localparam int          BUS_W       = 32;
    localparam int          STAT_PTR_W  = 18;
    localparam int          ADD_W       = 6;
    localparam logic [5:0]  ADD_CAP     = 6'h3F;
    localparam logic [12:0] REGION_TAG  = 13'd1;      // addr[31:19] for 0x80000..0xFFFFF
    localparam logic [10:0] OFS_ADD_RD  = 11'h000;
    localparam logic [10:0] OFS_ADD_WR  = 11'h004;
    localparam logic [10:0] OFS_STAT_RD = 11'h008;
    localparam logic [10:0] OFS_STAT_WR = 11'h00C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ADD_RD,
        SEL_ADD_WR,
        SEL_STAT_RD,
        SEL_STAT_WR
    } reg_sel_e;

    typedef struct packed {
        logic      hit;
        logic [7:0] qidx;
        reg_sel_e  sel;
    } dec_t;

    function automatic logic [ADD_W-1:0] clip_add(input logic [BUS_W-1:0] v);
        return (v > BUS_W'(ADD_CAP)) ? ADD_CAP : v[ADD_W-1:0];
    endfunction

    function automatic logic [BUS_W-1:0] mk_status(input logic flag,
                                                   input logic [STAT_PTR_W-1:0] ptr);
        return {flag, 13'd0, ptr};
    endfunction

endpackage

// File: rtl/mmq_addr_dec.sv
module mmq_addr_dec
    import mmq_pkg::*;
#(
    parameter int NUM_QUEUES = 4
) (
    input  logic [BUS_W-1:0] addr,
    output dec_t             dec
);

    logic     in_region;
    logic     q_valid;
    reg_sel_e sel;

    assign in_region = (addr[31:19] == REGION_TAG);
    assign q_valid   = (32'(addr[18:11]) < NUM_QUEUES);

    always_comb begin
        unique case (addr[10:0])
            OFS_ADD_RD:  sel = SEL_ADD_RD;
            OFS_ADD_WR:  sel = SEL_ADD_WR;
            OFS_STAT_RD: sel = SEL_STAT_RD;
            OFS_STAT_WR: sel = SEL_STAT_WR;
            default:     sel = SEL_NONE;
        endcase
    end

    always_comb begin
        dec.qidx = addr[18:11];
        dec.sel  = sel;
        dec.hit  = in_region && q_valid && (sel != SEL_NONE);
    end

endmodule

// File: rtl/mmq_queue_slice.sv
module mmq_queue_slice
    import mmq_pkg::*;
#(
    parameter int QSZ_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              add_rd,
    input  logic              add_wr,
    input  logic [ADD_W-1:0]  add_amt,
    output logic [QSZ_LOG2:0] rd_ptr,
    output logic [QSZ_LOG2:0] wr_ptr,
    output logic              empty,
    output logic              ovf
);

    localparam int                FILL_W = QSZ_LOG2 + 8;
    localparam logic [FILL_W-1:0] DEPTH  = FILL_W'(64'd1 << QSZ_LOG2);

    logic [QSZ_LOG2:0] diff;
    logic [FILL_W-1:0] fill_next;
    logic              over_hit;

    // fill level with one wrap bit is exact while the ring has not overflowed
    assign diff      = wr_ptr - rd_ptr;
    assign fill_next = FILL_W'(diff) + FILL_W'(add_amt);
    assign over_hit  = add_wr && (fill_next > DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            ovf    <= 1'b0;
        end else begin
            if (add_rd) rd_ptr <= rd_ptr + (QSZ_LOG2+1)'(add_amt);
            if (add_wr) wr_ptr <= wr_ptr + (QSZ_LOG2+1)'(add_amt);
            if (over_hit) ovf <= 1'b1;
        end
    end

    assign empty = (rd_ptr == wr_ptr);

endmodule

// File: rtl/mmq_rd_mux.sv
module mmq_rd_mux
    import mmq_pkg::*;
#(
    parameter int NUM_QUEUES = 4,
    parameter int QSZ_LOG2   = 6
) (
    input  dec_t                                 dec,
    input  logic [NUM_QUEUES-1:0][QSZ_LOG2:0]    rd_ptr_all,
    input  logic [NUM_QUEUES-1:0][QSZ_LOG2:0]    wr_ptr_all,
    input  logic [NUM_QUEUES-1:0]                ovf_all,
    input  logic [NUM_QUEUES-1:0]                empty_all,
    output logic [BUS_W-1:0]                     rdata_nxt
);

    always_comb begin
        rdata_nxt = '0;
        for (int q = 0; q < NUM_QUEUES; q++) begin
            if (dec.hit && (dec.qidx == 8'(q))) begin
                case (dec.sel)
                    SEL_STAT_RD: rdata_nxt = mk_status(ovf_all[q],
                                     STAT_PTR_W'(rd_ptr_all[q][QSZ_LOG2-1:0]));
                    SEL_STAT_WR: rdata_nxt = mk_status(empty_all[q],
                                     STAT_PTR_W'(wr_ptr_all[q][QSZ_LOG2-1:0]));
                    default:     rdata_nxt = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/mmq_ptr_ctrl.sv
module mmq_ptr_ctrl
    import mmq_pkg::*;
#(
    parameter int NUM_QUEUES = 4,
    parameter int QSZ_LOG2   = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] bus_addr,
    input  logic        bus_wr_en,
    input  logic [31:0] bus_wdata,
    input  logic        bus_rd_en,
    output logic [31:0] bus_rdata
);

    dec_t                              dec;
    logic [ADD_W-1:0]                  add_amt;
    logic [NUM_QUEUES-1:0][QSZ_LOG2:0] rd_ptr_all;
    logic [NUM_QUEUES-1:0][QSZ_LOG2:0] wr_ptr_all;
    logic [NUM_QUEUES-1:0]             ovf_all;
    logic [NUM_QUEUES-1:0]             empty_all;
    logic [BUS_W-1:0]                  rdata_nxt;

    mmq_addr_dec #(.NUM_QUEUES(NUM_QUEUES)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    assign add_amt = clip_add(bus_wdata);

    for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_queue
        logic sel_q;
        assign sel_q = bus_wr_en && dec.hit && (dec.qidx == 8'(g));

        mmq_queue_slice #(.QSZ_LOG2(QSZ_LOG2)) u_slice (
            .clk     (clk),
            .rst     (rst),
            .add_rd  (sel_q && (dec.sel == SEL_ADD_RD)),
            .add_wr  (sel_q && (dec.sel == SEL_ADD_WR)),
            .add_amt (add_amt),
            .rd_ptr  (rd_ptr_all[g]),
            .wr_ptr  (wr_ptr_all[g]),
            .empty   (empty_all[g]),
            .ovf     (ovf_all[g])
        );
    end

    mmq_rd_mux #(.NUM_QUEUES(NUM_QUEUES), .QSZ_LOG2(QSZ_LOG2)) u_mux (
        .dec        (dec),
        .rd_ptr_all (rd_ptr_all),
        .wr_ptr_all (wr_ptr_all),
        .ovf_all    (ovf_all),
        .empty_all  (empty_all),
        .rdata_nxt  (rdata_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)            bus_rdata <= '0;
        else if (bus_rd_en) bus_rdata <= rdata_nxt;
    end

endmodule

// File: rtl/mmq_ptr_ctrl_chk.sv
module mmq_ptr_ctrl_chk #(
    parameter int NUM_QUEUES = 4,
    parameter int QSZ_LOG2   = 6
) (
    input logic                              clk,
    input logic                              rst,
    input logic [31:0]                       bus_addr,
    input logic                              bus_wr_en,
    input logic                              bus_rd_en,
    input logic [31:0]                       bus_rdata,
    input logic [NUM_QUEUES-1:0][QSZ_LOG2:0] rd_ptr_all,
    input logic [NUM_QUEUES-1:0][QSZ_LOG2:0] wr_ptr_all,
    input logic [NUM_QUEUES-1:0]             ovf_all
);

    localparam int PTR_W = QSZ_LOG2 + 1;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_en |=> $stable(bus_rdata)); // R10

    AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && (bus_addr[31:19] != 13'd1)) |=> (bus_rdata == 32'h0)); // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((ovf_all & $past(ovf_all)) == $past(ovf_all))); // R6

    for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_q
        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
            !bus_wr_en |=> ($stable(rd_ptr_all[g]) && $stable(wr_ptr_all[g]))); // R8

        AST_WR_ADD_CAP: assert property (@(posedge clk) disable iff (rst)
            bus_wr_en |=> (32'(PTR_W'(wr_ptr_all[g] - $past(wr_ptr_all[g]))) <= 32'd63)); // R4

        AST_RD_ADD_CAP: assert property (@(posedge clk) disable iff (rst)
            bus_wr_en |=> (32'(PTR_W'(rd_ptr_all[g] - $past(rd_ptr_all[g]))) <= 32'd63)); // R4
    end

endmodule

bind mmq_ptr_ctrl mmq_ptr_ctrl_chk #(
    .NUM_QUEUES (NUM_QUEUES),
    .QSZ_LOG2   (QSZ_LOG2)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr_en  (bus_wr_en),
    .bus_rd_en  (bus_rd_en),
    .bus_rdata  (bus_rdata),
    .rd_ptr_all (rd_ptr_all),
    .wr_ptr_all (wr_ptr_all),
    .ovf_all    (ovf_all)
);

// File: tb/mmq_ptr_ctrl_tb.sv
`timescale 1ns/1ps
module mmq_ptr_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd_en = 1'b0;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #2 clk = ~clk;   // 250 MHz

    mmq_ptr_ctrl #(.NUM_QUEUES(4), .QSZ_LOG2(6)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr_en (bus_wr_en),
        .bus_wdata (bus_wdata),
        .bus_rd_en (bus_rd_en),
        .bus_rdata (bus_rdata)
    );

    function automatic logic [31:0] qa(input int q, input logic [31:0] ofs);
        return 32'h0008_0000 + 32'(q) * 32'h800 + ofs;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_rd_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic expect_rd(input string tag, input logic [31:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(tag, d, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rdata after reset", bus_rdata, 32'h0);
        expect_rd("R1 q0 read status", qa(0, 32'h8), 32'h0);
        expect_rd("R1 q0 write status empty", qa(0, 32'hC), 32'h8000_0000);
        expect_rd("R1 q3 write status empty", qa(3, 32'hC), 32'h8000_0000);
    endtask

    task automatic t_write_add();
        bus_write(qa(0, 32'h4), 32'd5);
        expect_rd("R2 q0 write ptr 5", qa(0, 32'hC), 32'h0000_0005);
        expect_rd("R2 q0 read ptr still 0", qa(0, 32'h8), 32'h0);
    endtask

    task automatic t_read_add();
        bus_write(qa(0, 32'h0), 32'd3);
        expect_rd("R3 q0 read ptr 3", qa(0, 32'h8), 32'h0000_0003);
        bus_write(qa(0, 32'h0), 32'd2);
        expect_rd("R3 q0 read ptr 5", qa(0, 32'h8), 32'h0000_0005);
        expect_rd("R7 q0 empty after catch-up", qa(0, 32'hC), 32'h8000_0005);
    endtask

    task automatic t_clip();
        bus_write(qa(1, 32'h4), 32'h0000_1000);
        expect_rd("R4 q1 add clipped to 63", qa(1, 32'hC), 32'h0000_003F);
        bus_write(qa(1, 32'h4), 32'h0);
        expect_rd("R4 q1 zero write add", qa(1, 32'hC), 32'h0000_003F);
        bus_write(qa(1, 32'h0), 32'h0);
        expect_rd("R4 q1 zero read add", qa(1, 32'h8), 32'h0);
    endtask

    task automatic t_full_and_wrap();
        bus_write(qa(1, 32'h4), 32'd1);           // fill = 64 = depth
        expect_rd("R7 q1 full not empty", qa(1, 32'hC), 32'h0000_0000);
        expect_rd("R6 q1 fill equal depth no ovf", qa(1, 32'h8), 32'h0);
        bus_write(qa(1, 32'h0), 32'd63);
        bus_write(qa(1, 32'h0), 32'd1);           // rd = 64 -> wraps to 0
        expect_rd("R5 q1 read ptr wrapped", qa(1, 32'h8), 32'h0);
        expect_rd("R7 q1 empty after wrap", qa(1, 32'hC), 32'h8000_0000);
        bus_write(qa(1, 32'h4), 32'd10);
        expect_rd("R5 q1 write ptr past wrap", qa(1, 32'hC), 32'h0000_000A);
        bus_write(qa(1, 32'h0), 32'd10);
        expect_rd("R5 q1 read ptr past wrap", qa(1, 32'h8), 32'h0000_000A);
    endtask

    task automatic t_overflow();
        bus_write(qa(2, 32'h4), 32'd63);
        bus_write(qa(2, 32'h4), 32'd2);           // fill 65 > 64
        expect_rd("R6 q2 overflow set", qa(2, 32'h8), 32'h8000_0000);
        expect_rd("R6 q2 write ptr still advanced", qa(2, 32'hC), 32'h0000_0001);
        bus_write(qa(2, 32'h0), 32'd63);
        expect_rd("R6 q2 overflow sticky", qa(2, 32'h8), 32'h8000_003F);
    endtask

    task automatic t_isolation();
        expect_rd("R8 q3 read ptr untouched", qa(3, 32'h8), 32'h0);
        expect_rd("R8 q3 write ptr untouched", qa(3, 32'hC), 32'h8000_0000);
        expect_rd("R8 q0 untouched by others", qa(0, 32'hC), 32'h8000_0005);
    endtask

    task automatic t_unmapped();
        bus_write(qa(3, 32'h10), 32'd5);
        bus_write(qa(4, 32'h4), 32'd7);
        bus_write(32'h0000_0004, 32'd7);
        bus_write(32'h0010_0004, 32'd7);
        expect_rd("R9 q3 unchanged by bad writes", qa(3, 32'hC), 32'h8000_0000);
        expect_rd("R9 q0 unchanged by bad writes", qa(0, 32'hC), 32'h8000_0005);
        expect_rd("R9 add offset reads zero", qa(0, 32'h4), 32'h0);
        expect_rd("R9 bad offset reads zero", qa(0, 32'h10), 32'h0);
        expect_rd("R9 queue index out of range", qa(4, 32'hC), 32'h0);
        expect_rd("R9 below region", 32'h0000_000C, 32'h0);
        expect_rd("R9 above region", 32'h0010_000C, 32'h0);
    endtask

    task automatic t_rdata_hold();
        expect_rd("R10 q0 status before hold", qa(0, 32'hC), 32'h8000_0005);
        bus_write(qa(0, 32'h4), 32'd1);
        repeat (2) @(negedge clk);
        check("R10 rdata held without strobe", bus_rdata, 32'h8000_0005);
        expect_rd("R10 fresh read after add", qa(0, 32'hC), 32'h0000_0006);
    endtask

    task automatic t_reset_clears();
        do_reset();
        expect_rd("R1 overflow cleared by reset", qa(2, 32'h8), 32'h0);
        expect_rd("R1 q1 empty after reset", qa(1, 32'hC), 32'h8000_0000);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write_add();
        t_read_add();
        t_clip();
        t_full_and_wrap();
        t_overflow();
        t_isolation();
        t_unmapped();
        t_rdata_hold();
        t_reset_clears();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule